// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read side of a synchronous burst memory. A 16-bit configuration word, written through a one-cycle write strobe, selects burst or page operation, a first-access latency, a burst length of 4, 8 or unbounded words, wrap or straight increment, interleaved or linear word order, a one- or two-clock hold per word, and the polarity and timing of a WAIT output. With chip enable high and burst operation selected, an address strobe captures a start address. After the programmed latency, the block streams words from its storage onto the data bus, with a data-valid flag. The storage is modelled as a computed array: each word equals its address XOR a seed.

When words run in straight increment order, each crossing of a 16-word row costs one stall cycle, which WAIT reports. Dropping chip enable, or writing the configuration, abandons the burst on the next clock edge.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration word is 16'h9081, with page operation selected (bit 15 = 1). `dataValid` is 0, `cfgErr` is 0, `waitOut` is at its inactive level (1, because bit 10 = 0), and address strobes are ignored while bit 15 is 1.
- R2: Bits 13:11 hold the latency code LC, and codes 2 to 5 are legal. If the strobe is sampled high at edge E0, `dataValid` is first 1 after edge E(LC+2) and is 0 after all earlier edges.
- R3: `cfgErr` is 1 whenever any of these holds: LC is 0, 1, 6 or 7; bits 2:0 are not 001, 010 or 111; or any of bits 14, 6, 5, 4 is 1. While `cfgErr` is 1, strobes are ignored and `dataValid` stays 0. A legal write clears `cfgErr`.
- R4: A word read from address A (8 bits by default) is the address zero-extended to 16 bits, XOR 16'hC3A5.
- R5: Bits 2:0 set the burst length: 001 gives 4 words and 010 gives 8 words. After the last word, `dataValid` returns to 0.
- R6: With bit 7 = 0 and bit 3 = 0, word k of a burst of length L has address (start with its low log2(L) bits cleared) OR ((start XOR k) mod L).
- R7: With bit 7 = 1 and bit 3 = 0, word k has the same block base, and its offset is (start + k) mod L.
- R8: With bit 3 = 1, word k has address start + k (mod 2^AW), whatever bit 7 holds, and the burst still has L words.
- R9: Bits 2:0 = 111 give a continuous burst at start + k that runs until it is stopped.
- R10: Bit 9 = 0 holds each word for one clock; bit 9 = 1 holds each word for two consecutive valid clocks.
- R11: In modes R8 and R9, when the next word's address is a multiple of 16, one cycle with `dataValid` = 0 is inserted before that word.
- R12: WAIT is active during each stall cycle when bit 8 = 0. When bit 8 = 1 it is active during the last valid cycle before each stall instead. Bit 10 = 1 makes the active level high, and bit 10 = 0 makes it low.
- R13: If `chipEn` is sampled low, or a configuration write is sampled, `dataValid` is 0 after that edge and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIn | input | 16 | Configuration word |
| chipEn | input | 1 | Chip enable, active high |
| addrValid | input | 1 | Address strobe, active high |
| addrIn | input | AW (8) | Start address |
| dataOut | output | DW (16) | Read data |
| dataValid | output | 1 | Data word valid this cycle |
| waitOut | output | 1 | WAIT, polarity set by bit 10 |
| cfgErr | output | 1 | Reserved configuration code loaded |

## Verification
For each burst, the bench numbers the clock edges that follow the capture edge. The first word is due right after edge LC+2. Each later word follows its predecessor after one or two edges, plus one more edge at a row stall. WAIT in early mode leads the stall by exactly one cycle. Chip-enable loss and configuration writes take effect after the single edge that samples them. The bench builds the full expected per-edge trace of valid, data and WAIT from the requirements. It drives inputs on falling edges and compares every edge's outputs at the following falling edge, so each result is read in the cycle it is due.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef struct packed {
    logic       pageMode;
    logic [2:0] latCode;
    logic       waitHigh;
    logic       holdTwo;
    logic       waitEarly;
    logic       linearOrder;
    logic       noWrap;
    logic [2:0] lenCode;
    logic [3:0] spare;
  } cfgT;

  typedef struct packed {
    logic capture;
    logic step;
    logic show;
  } strobeT;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA, S_STALL} stateT;

  function automatic cfgT unpackCfg(input logic [15:0] w);
    cfgT c;
    c.pageMode    = w[15];
    c.latCode     = w[13:11];
    c.waitHigh    = w[10];
    c.holdTwo     = w[9];
    c.waitEarly   = w[8];
    c.linearOrder = w[7];
    c.noWrap      = w[3];
    c.lenCode     = w[2:0];
    c.spare       = {w[14], w[6:4]};
    return c;
  endfunction

  function automatic logic cfgBad(input cfgT c);
    logic latBad, lenBad;
    latBad = (c.latCode < 3'd2) || (c.latCode > 3'd5);
    lenBad = !((c.lenCode == 3'b001) || (c.lenCode == 3'b010) || (c.lenCode == 3'b111));
    return latBad || lenBad || (c.spare != 4'd0);
  endfunction

endpackage

// File: rtl/brs_datapath.sv
module brs_datapath
  import brs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] SEED = 16'hC3A5,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [AW-1:0] addrIn,
  input  logic          noWrap,
  input  logic          linearOrder,
  input  logic [2:0]    lenCode,
  output logic [DW-1:0] dataOut,
  output logic          crossNext,
  output logic          lastWord
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);

  logic [AW-1:0] startAddr, idx;
  logic [AW-1:0] blockMask, curAddr, nextAddr, selAddr;
  logic          contMode, runMode;

  function automatic logic [AW-1:0] addrOf(input logic [AW-1:0] s, input logic [AW-1:0] k,
                                           input logic run, input logic lin,
                                           input logic [AW-1:0] m);
    if (run) return s + k;
    if (!lin) return (s & ~m) | ((s ^ k) & m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  always_comb begin
    contMode  = (lenCode == 3'b111);
    runMode   = noWrap || contMode;
    blockMask = (lenCode == 3'b001) ? AW'(3) : AW'(7);
    curAddr   = addrOf(startAddr, idx, runMode, linearOrder, blockMask);
    nextAddr  = addrOf(startAddr, idx + AW'(1), runMode, linearOrder, blockMask);
    crossNext = runMode && (nextAddr[ROW_BITS-1:0] == '0);
    lastWord  = !contMode && (idx == blockMask);
    selAddr   = stb.step ? nextAddr : curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      idx       <= '0;
      dataOut   <= '0;
    end else begin
      if (stb.capture) begin
        startAddr <= addrIn;
        idx       <= '0;
      end else if (stb.step) begin
        idx <= idx + AW'(1);
      end
      if (stb.show) dataOut <= DW'(selAddr) ^ SEED;
    end
  end

  // Word address stays inside its block when wrapping finite bursts
  AST_WRAP_STAYS_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.show && !runMode) |=> ((dataOut ^ SEED) & DW'(~blockMask)) == DW'(startAddr & ~blockMask)); // R6
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter logic [15:0] CFG_RESET = 16'h9081,
  parameter int CW = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [15:0] cfgIn,
  input  logic        chipEn,
  input  logic        addrValid,
  input  logic        crossNext,
  input  logic        lastWord,
  output strobeT      stb,
  output logic        noWrap,
  output logic        linearOrder,
  output logic [2:0]  lenCode,
  output logic        holdTwo,
  output logic        dataValid,
  output logic        waitOut,
  output logic        cfgErr
);
  cfgT           cfg;
  stateT         state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic          holdLeft, holdNxt, waitAct;

  always_comb begin
    cfgErr      = cfgBad(cfg);
    noWrap      = cfg.noWrap;
    linearOrder = cfg.linearOrder;
    lenCode     = cfg.lenCode;
    holdTwo     = cfg.holdTwo;
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    holdNxt  = holdLeft;
    stb      = '0;
    if (cfgWe || !chipEn) begin
      stateNxt = S_IDLE;
    end else if (addrValid && !cfg.pageMode && !cfgErr) begin
      stateNxt    = S_LAT;
      stb.capture = 1'b1;
      cntNxt      = CW'(cfg.latCode) + CW'(2);
    end else begin
      unique case (state)
        S_LAT: begin
          if (cnt == CW'(1)) begin
            stateNxt = S_DATA;
            stb.show = 1'b1;
            holdNxt  = cfg.holdTwo;
          end else begin
            cntNxt = cnt - CW'(1);
          end
        end
        S_DATA: begin
          if (holdLeft) begin
            holdNxt = 1'b0;
          end else if (lastWord) begin
            stateNxt = S_IDLE;
          end else if (crossNext) begin
            stateNxt = S_STALL;
            stb.step = 1'b1;
          end else begin
            stb.step = 1'b1;
            stb.show = 1'b1;
            holdNxt  = cfg.holdTwo;
          end
        end
        S_STALL: begin
          stateNxt = S_DATA;
          stb.show = 1'b1;
          holdNxt  = cfg.holdTwo;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= unpackCfg(CFG_RESET);
      state    <= S_IDLE;
      cnt      <= '0;
      holdLeft <= 1'b0;
    end else begin
      if (cfgWe) cfg <= unpackCfg(cfgIn);
      state    <= stateNxt;
      cnt      <= cntNxt;
      holdLeft <= holdNxt;
    end
  end

  always_comb begin
    dataValid = (state == S_DATA);
    waitAct   = cfg.waitEarly ? ((state == S_DATA) && !holdLeft && crossNext && !lastWord)
                              : (state == S_STALL);
    waitOut   = cfg.waitHigh ? waitAct : !waitAct;
  end

  AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn || cfgWe) |=> !dataValid); // R13
  AST_NO_DATA_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !dataValid); // R3
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STALL) |=> (state != S_STALL)); // R11
  AST_FIRST_WORD_AFTER_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LAT && cnt > CW'(1) && chipEn && !cfgWe && !addrValid) |=> !dataValid); // R2
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] SEED = 16'hC3A5,
  parameter logic [15:0] CFG_RESET = 16'h9081
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [15:0]   cfgIn,
  input  logic          chipEn,
  input  logic          addrValid,
  input  logic [AW-1:0] addrIn,
  output logic [DW-1:0] dataOut,
  output logic          dataValid,
  output logic          waitOut,
  output logic          cfgErr
);
  strobeT     stb;
  logic       noWrap, linearOrder, holdTwo, crossNext, lastWord;
  logic [2:0] lenCode;

  brs_ctrl #(.CFG_RESET(CFG_RESET)) u_ctrl (
    .clk, .rstN, .cfgWe, .cfgIn, .chipEn, .addrValid,
    .crossNext, .lastWord, .stb, .noWrap, .linearOrder, .lenCode,
    .holdTwo, .dataValid, .waitOut, .cfgErr
  );

  brs_datapath #(.AW(AW), .DW(DW), .SEED(SEED)) u_dp (
    .clk, .rstN, .stb, .addrIn, .noWrap, .linearOrder, .lenCode,
    .dataOut, .crossNext, .lastWord
  );

  AST_HOLD_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataValid) && holdTwo && chipEn && !cfgWe && !addrValid)
      |=> (dataValid && $stable(dataOut))); // R10
endmodule

// File: tb/burst_read_seq_tb.sv
`timescale 1ns/1ps
module burst_read_seq_tb;
  localparam logic [15:0] SEED = 16'hC3A5;
  localparam int NV = 8;
  localparam logic [15:0] V_CFG [NV] = '{16'h1001, 16'h1882, 16'h2602, 16'h288A,
                                         16'h1587, 16'h1207, 16'h1909, 16'h1201};
  localparam logic [7:0]  V_START [NV] = '{8'h26, 8'h35, 8'h4B, 8'h1D,
                                           8'h0E, 8'hFD, 8'h0F, 8'h07};
  localparam int          V_CYC [NV] = '{12, 16, 24, 20, 30, 20, 14, 16};

  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, chipEn = 1'b1, addrValid = 1'b0;
  logic [15:0] cfgIn = '0;
  logic [7:0]  addrIn = '0;
  logic [15:0] dataOut;
  logic dataValid, waitOut, cfgErr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic        expV [64];
  logic [15:0] expD [64];
  logic        expW [64];

  always #4 clk = ~clk;

  burst_read_seq u_dut (
    .clk, .rstN, .cfgWe, .cfgIn, .chipEn, .addrValid, .addrIn,
    .dataOut, .dataValid, .waitOut, .cfgErr
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R2 R4 R5 R6";
      1: return "R2 R7 R5";
      2: return "R6 R10 R12";
      3: return "R8 R11 R12";
      4: return "R9 R11 R12";
      5: return "R9 R10 R11";
      6: return "R8 R11 R12";
      default: return "R6 R10";
    endcase
  endfunction

  function automatic logic [7:0] expAddr(input logic [15:0] c, input logic [7:0] s, input int k);
    logic [7:0] m, kk;
    kk = 8'(k);
    m  = (c[2:0] == 3'b001) ? 8'd3 : 8'd7;
    if (c[2:0] == 3'b111 || c[3]) return s + kk;
    if (!c[7]) return (s & ~m) | ((s ^ kk) & m);
    return (s & ~m) | ((s + kk) & m);
  endfunction

  task automatic buildTrace(input logic [15:0] c, input logic [7:0] s, input int n);
    int t, k, words, hold;
    bit run;
    logic [7:0] a;
    for (int i = 0; i < 64; i++) begin expV[i] = 0; expD[i] = '0; expW[i] = 0; end
    run   = (c[2:0] == 3'b111) || c[3];
    words = (c[2:0] == 3'b111) ? 1000 : ((c[2:0] == 3'b001) ? 4 : 8);
    hold  = c[9] ? 2 : 1;
    t = int'(c[13:11]) + 2;
    k = 0;
    while (t <= n && k < words) begin
      a = expAddr(c, s, k);
      if (k > 0 && run && a[3:0] == 4'h0) begin
        if (c[8]) expW[t-1] = 1; else expW[t] = 1;
        t++;
      end
      for (int h = 0; h < hold; h++) begin
        if (t < 64) begin expV[t] = 1; expD[t] = {8'h00, a} ^ SEED; end
        t++;
      end
      k++;
    end
  endtask

  task automatic writeCfg(input logic [15:0] c);
    @(negedge clk); cfgWe = 1; cfgIn = c;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic strobe(input logic [7:0] a);
    @(negedge clk); addrValid = 1; addrIn = a;
    @(posedge clk);
    @(negedge clk); addrValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seen;
    logic [15:0] c;
    logic pol;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(dataValid == 0, "R1 dataValid after reset", 32'(dataValid), 0);
    check(cfgErr == 0, "R1 cfgErr after reset", 32'(cfgErr), 0);
    check(waitOut == 1, "R1 waitOut idle level", 32'(waitOut), 1);
    strobe(8'h10);
    seen = 0;
    repeat (12) begin @(negedge clk); if (dataValid) seen++; end
    check(seen == 0, "R1 strobe ignored in page mode", seen, 0);

    for (int i = 0; i < NV; i++) begin
      c = V_CFG[i];
      pol = c[10];
      writeCfg(c);
      buildTrace(c, V_START[i], V_CYC[i]);
      @(negedge clk); addrValid = 1; addrIn = V_START[i];
      @(posedge clk);
      @(negedge clk); addrValid = 0;
      for (int j = 1; j <= V_CYC[i]; j++) begin
        @(posedge clk);
        @(negedge clk);
        check(dataValid == expV[j], $sformatf("%s valid v%0d edge %0d", tagOf(i), i, j),
              32'(dataValid), 32'(expV[j]));
        if (expV[j])
          check(dataOut == expD[j], $sformatf("%s data v%0d edge %0d", tagOf(i), i, j),
                32'(dataOut), 32'(expD[j]));
        check(waitOut == (pol ? expW[j] : !expW[j]),
              $sformatf("%s wait v%0d edge %0d", tagOf(i), i, j),
              32'(waitOut), 32'(pol ? expW[j] : !expW[j]));
      end
    end

    // R3 reserved latency code
    writeCfg(16'h0001);
    @(negedge clk);
    check(cfgErr == 1, "R3 reserved latency flags error", 32'(cfgErr), 1);
    strobe(8'h20);
    seen = 0;
    repeat (12) begin @(negedge clk); if (dataValid) seen++; end
    check(seen == 0, "R3 no data while error", seen, 0);
    writeCfg(16'h1003);
    check(cfgErr == 1, "R3 reserved length flags error", 32'(cfgErr), 1);
    writeCfg(16'h1001);
    check(cfgErr == 0, "R3 legal write clears error", 32'(cfgErr), 0);

    // R13 chip enable drop ends continuous burst
    writeCfg(16'h1007);
    strobe(8'h40);
    repeat (4) @(negedge clk);
    check(dataValid == 1, "R9 continuous burst running", 32'(dataValid), 1);
    chipEn = 0;
    @(negedge clk);
    check(dataValid == 0, "R13 chipEn low stops data", 32'(dataValid), 0);
    chipEn = 1;
    seen = 0;
    repeat (8) begin @(negedge clk); if (dataValid) seen++; end
    check(seen == 0, "R13 idle after chipEn drop", seen, 0);

    // R13 configuration write ends burst
    strobe(8'h50);
    repeat (5) @(negedge clk);
    check(dataValid == 1, "R9 second continuous burst running", 32'(dataValid), 1);
    cfgWe = 1; cfgIn = 16'h1007;
    @(negedge clk); cfgWe = 0;
    check(dataValid == 0, "R13 config write stops data", 32'(dataValid), 0);
    seen = 0;
    repeat (8) begin @(negedge clk); if (dataValid) seen++; end
    check(seen == 0, "R13 idle after config write", seen, 0);

    finishRun();
  end
endmodule